// File: doc/BRIEF.md
# Processor Trace Pin Multiplexer

This block brings the execution-stage program counter and the instruction-valid strobe of a soft processor out to a small group of debug pins, where an external logic analyser can capture them. Two measures shrink the pin count. First, only the address bits that actually change are traced: the two alignment bits are dropped, because every instruction sits on a 4-byte boundary, and so are a configurable number of top bits that stay constant in a given design. Second, each pin carries two signals per clock, one in the high phase and one in the low phase. A register pipeline of configurable depth lies between the processor and the pins, so that the trace tap adds little to the critical paths.

A host strobe starts a channel-discovery sequence. The block then sends a fixed 8-bit training pattern on pin 0 alone, then on pin 1, and so on up to the last pin. The analyser can then work out which of its channels is wired to which pin. When the last pin has been trained, the block goes back to normal trace output and pulses a completion flag.

Top module: `trace_pin_mux`

## Requirements
- R1: The traced signal list is built as follows. Signal 0 is the valid strobe. Signal i+1 is program counter bit i+2, for i from 0 to ADDR_W-STATIC_HI-3. Program counter bits 1:0 and the top STATIC_HI bits have no effect on the pins.
- R2: Pin k carries signal 2k in its high-phase slot and signal 2k+1 in its low-phase slot. If the signal count is odd, the low-phase slot of the last pin is 0.
- R3: While the clock is high, the pins show the high-phase slots. While the clock is low, they show the low-phase slots. Both slots change only at the rising edge.
- R4: A trace input captured at rising edge e appears on the pins after rising edge e+PIPE_DEPTH-1.
- R5: While reset is asserted, all pins are 0 in both phases and the done flag is 0.
- R6: A start strobe captured at edge g begins training output after edge g+1. The selected pin sends the pattern 8'b1011_0010 MSB first, two bits per clock (high phase first), so one repetition takes 4 cycles. Each pin is held for TRAIN_REPS repetitions, and pins are trained in ascending order from pin 0.
- R7: During training, every pin other than the selected one is 0 in both phases.
- R8: The done flag is high for exactly one cycle, in the same cycle as the last training output, that is, after edge g+PIN_N*4*TRAIN_REPS. In the next cycle the pins carry trace data again under R4 timing.
- R9: A start strobe during training restarts the sequence from pin 0. A strobe in the final training cycle suppresses that run's done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; its level also selects the pin slot |
| rstN | input | 1 | Asynchronous active-low reset |
| pcEx | input | ADDR_W | Execution-stage program counter |
| pcValid | input | 1 | Instruction-valid strobe |
| setupGo | input | 1 | One-cycle strobe that starts training |
| setupDone | output | 1 | One-cycle pulse when training ends |
| tracePins | output | PIN_N | Shared debug pins |

## Verification
The bench records every trace value it presents and expects that value on the pins PIPE_DEPTH-1 edges after the capture edge. It samples the high-phase slot 1 ns after each rising edge and the low-phase slot 1 ns after each falling edge. For training, it numbers each cycle from the last start strobe: cycle d after the strobe edge shows pattern pair (d-1) mod 4 on pin (d-1)/(4*TRAIN_REPS), and the done flag is expected exactly at d = PIN_N*4*TRAIN_REPS unless a new strobe arrives on that edge. The two models share one timeline, so every sample is checked against exactly one of them, including the cycles where training hands back to trace.

// File: rtl/trace_pin_pkg.sv
package trace_pin_pkg;
  localparam int SEL_W = 8;
  localparam logic [7:0] TRAIN_PATTERN = 8'b1011_0010;

  typedef struct packed {
    logic             trainEn;
    logic [SEL_W-1:0] pinSel;
    logic             riseBit;
    logic             fallBit;
  } trainCtl_t;
endpackage

// File: rtl/trace_train_ctrl.sv
module trace_train_ctrl
  import trace_pin_pkg::*;
#(
  parameter int PIN_N      = 10,
  parameter int TRAIN_REPS = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      setupGo,
  output trainCtl_t ctl,
  output logic      setupDone
);
  localparam int REP_W = (TRAIN_REPS > 1) ? $clog2(TRAIN_REPS) : 1;
  localparam logic [REP_W-1:0] LAST_REP = REP_W'(TRAIN_REPS - 1);
  localparam logic [SEL_W-1:0] LAST_PIN = SEL_W'(PIN_N - 1);

  logic             trainOn;
  logic [SEL_W-1:0] pinIdx;
  logic [1:0]       phase;
  logic [REP_W-1:0] repCnt;
  logic [2:0]       riseIdx;
  logic [2:0]       fallIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trainOn   <= 1'b0;
      pinIdx    <= '0;
      phase     <= '0;
      repCnt    <= '0;
      setupDone <= 1'b0;
    end else begin
      setupDone <= 1'b0;
      if (setupGo) begin
        trainOn <= 1'b1;
        pinIdx  <= '0;
        phase   <= '0;
        repCnt  <= '0;
      end else if (trainOn) begin
        phase <= phase + 2'd1;
        if (phase == 2'd3) begin
          if (repCnt == LAST_REP) begin
            repCnt <= '0;
            if (pinIdx == LAST_PIN) begin
              trainOn   <= 1'b0;
              setupDone <= 1'b1;
            end else begin
              pinIdx <= pinIdx + 1'b1;
            end
          end else begin
            repCnt <= repCnt + 1'b1;
          end
        end
      end
    end
  end

  // Each cycle sends two pattern bits, MSB first.
  assign riseIdx = 3'd7 - {phase, 1'b0};
  assign fallIdx = 3'd6 - {phase, 1'b0};

  always_comb begin
    ctl.trainEn = trainOn;
    ctl.pinSel  = pinIdx;
    ctl.riseBit = TRAIN_PATTERN[riseIdx];
    ctl.fallBit = TRAIN_PATTERN[fallIdx];
  end

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    setupDone |=> !setupDone);
  a_r8_done_ends_train: assert property (@(posedge clk) disable iff (!rstN)
    setupDone |-> (!ctl.trainEn && $past(ctl.trainEn)));
  a_r9_restart_pin0: assert property (@(posedge clk) disable iff (!rstN)
    setupGo |=> (ctl.trainEn && ctl.pinSel == '0));
  a_r6_pin_in_range: assert property (@(posedge clk) disable iff (!rstN)
    ctl.trainEn |-> (ctl.pinSel < SEL_W'(PIN_N)));
endmodule

// File: rtl/trace_pin_datapath.sv
module trace_pin_datapath
  import trace_pin_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int STATIC_HI  = 12,
  parameter int PIPE_DEPTH = 4,
  parameter int PIN_N      = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] pcEx,
  input  logic              pcValid,
  input  trainCtl_t         ctl,
  output logic [PIN_N-1:0]  tracePins
);
  localparam int KEEP_HI = ADDR_W - STATIC_HI - 1;
  localparam int KEEP_W  = KEEP_HI - 1;
  localparam int PAD_N   = 2 * PIN_N;

  logic [PAD_N-1:0] sigVec;
  logic [PIN_N-1:0] riseIn, fallIn;
  logic [PIN_N-1:0] trainRise, trainFall;
  logic [PIN_N-1:0] riseStage [PIPE_DEPTH-1];
  logic [PIN_N-1:0] fallStage [PIPE_DEPTH-1];
  logic [PIN_N-1:0] riseOut, fallOut;
  logic             unusedPcBits;

  assign unusedPcBits = ^{pcEx[ADDR_W-1:KEEP_HI+1], pcEx[1:0]};

  always_comb begin
    sigVec           = '0;
    sigVec[0]        = pcValid;
    sigVec[KEEP_W:1] = pcEx[KEEP_HI:2];
  end

  for (genvar k = 0; k < PIN_N; k++) begin : g_pair
    assign riseIn[k]    = sigVec[2*k];
    assign fallIn[k]    = sigVec[2*k+1];
    assign trainRise[k] = ctl.riseBit && (ctl.pinSel == SEL_W'(k));
    assign trainFall[k] = ctl.fallBit && (ctl.pinSel == SEL_W'(k));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < PIPE_DEPTH - 1; i++) begin
        riseStage[i] <= '0;
        fallStage[i] <= '0;
      end
      riseOut <= '0;
      fallOut <= '0;
    end else begin
      riseStage[0] <= riseIn;
      fallStage[0] <= fallIn;
      for (int i = 1; i < PIPE_DEPTH - 1; i++) begin
        riseStage[i] <= riseStage[i-1];
        fallStage[i] <= fallStage[i-1];
      end
      riseOut <= ctl.trainEn ? trainRise : riseStage[PIPE_DEPTH-2];
      fallOut <= ctl.trainEn ? trainFall : fallStage[PIPE_DEPTH-2];
    end
  end

  // Dual-edge pin model: high phase shows the first slot, low phase the second.
  assign tracePins = clk ? riseOut : fallOut;

  a_r7_one_pin_active: assert property (@(posedge clk) disable iff (!rstN)
    ctl.trainEn |=> ($countones(riseOut | fallOut) <= 1));
  a_r7_selected_pin_only: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.trainEn && ctl.pinSel == '0) |=> ((riseOut | fallOut) >> 1) == '0);
endmodule

// File: rtl/trace_pin_mux.sv
module trace_pin_mux
  import trace_pin_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int STATIC_HI  = 12,
  parameter int PIPE_DEPTH = 4,
  parameter int TRAIN_REPS = 4,
  localparam int KEEP_W    = ADDR_W - STATIC_HI - 2,
  localparam int SIG_N     = KEEP_W + 1,
  localparam int PIN_N     = (SIG_N + 1) / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] pcEx,
  input  logic              pcValid,
  input  logic              setupGo,
  output logic              setupDone,
  output logic [PIN_N-1:0]  tracePins
);
  trainCtl_t ctl;

  trace_train_ctrl #(
    .PIN_N      (PIN_N),
    .TRAIN_REPS (TRAIN_REPS)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .setupGo   (setupGo),
    .ctl       (ctl),
    .setupDone (setupDone)
  );

  trace_pin_datapath #(
    .ADDR_W     (ADDR_W),
    .STATIC_HI  (STATIC_HI),
    .PIPE_DEPTH (PIPE_DEPTH),
    .PIN_N      (PIN_N)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .pcEx      (pcEx),
    .pcValid   (pcValid),
    .ctl       (ctl),
    .tracePins (tracePins)
  );
endmodule

// File: tb/trace_pin_mux_bench.sv
module trace_pin_mux_bench;
  localparam int ADDR_W = 32;
  localparam int STATIC_HI = 24;
  localparam int DEPTH = 4;
  localparam int REPS = 2;
  localparam int PINS = 4;
  localparam int TRAIN_LEN = PINS * 4 * REPS;
  localparam logic [7:0] PAT = 8'b1011_0010;
  localparam int LAST_TICK = 530;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rstN;
  logic [ADDR_W-1:0] pcEx;
  logic              pcValid;
  logic              setupGo;
  logic              setupDone;
  logic [PINS-1:0]   tracePins;

  trace_pin_mux #(
    .ADDR_W(ADDR_W), .STATIC_HI(STATIC_HI),
    .PIPE_DEPTH(DEPTH), .TRAIN_REPS(REPS)
  ) u_trace_pin_mux (
    .clk(clk), .rstN(rstN), .pcEx(pcEx), .pcValid(pcValid),
    .setupGo(setupGo), .setupDone(setupDone), .tracePins(tracePins)
  );

  int tests = 0;
  int fails = 0;
  bit finished = 0;
  logic [ADDR_W-1:0] histPc [0:1023];
  logic              histV  [0:1023];
  int lastGo = -100000;

  task automatic chk(input string req, input logic [PINS-1:0] act, input logic [PINS-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expSig(input logic [ADDR_W-1:0] pc, input logic v);
    expSig = {1'b0, pc[7:2], v};
  endfunction

  function automatic logic goAt(input int m);
    goAt = (m == 300) || (m == 350) || (m == 362) || (m == 420) || (m == 452);
  endfunction

  logic [PINS-1:0] rs, fs;
  logic            dn;

  task automatic drive_sample(input logic [ADDR_W-1:0] pc, input logic v, input logic go);
    pcEx = pc; pcValid = v; setupGo = go;
    @(posedge clk); #1;
    rs = tracePins; dn = setupDone;
    #2;
    fs = tracePins;
  endtask

  task automatic tick(input int m);
    logic [ADDR_W-1:0] pc;
    logic v, go;
    logic [PINS-1:0] er, ef;
    logic [7:0] s;
    int d, j, pin, ph, idx;
    pc = {24'(m * 24'h5A5A5B), 8'(m)};
    v  = m[0] ^ m[3] ^ m[6];
    go = goAt(m);
    histPc[m] = pc; histV[m] = v;
    drive_sample(pc, v, go);
    d = m - lastGo;
    if (d >= 1 && d <= TRAIN_LEN) begin
      j = d - 1; pin = j / (4 * REPS); ph = j % 4;
      er = PINS'(PAT[7 - 2*ph]) << pin;
      ef = PINS'(PAT[6 - 2*ph]) << pin;
      chk("R6 R7 R9 training high slot", rs, er);
      chk("R6 R7 R9 training low slot", fs, ef);
    end else begin
      idx = m - (DEPTH - 1);
      s = (idx >= 0) ? expSig(histPc[idx], histV[idx]) : 8'h00;
      for (int k = 0; k < PINS; k++) begin
        er[k] = s[2*k];
        ef[k] = s[2*k+1];
      end
      chk("R1 R2 R4 R8 trace high slot", rs, er);
      chk("R2 R3 trace low slot", fs, ef);
    end
    chk("R8 R9 done flag", PINS'(dn), PINS'((d == TRAIN_LEN) && !go));
    if (go) lastGo = m;
  endtask

  initial begin
    rstN = 1'b0; pcEx = '1; pcValid = 1'b1; setupGo = 1'b0;
    for (int r = 0; r < 3; r++) begin
      @(posedge clk); #1;
      chk("R5 reset high slot", tracePins, '0);
      chk("R5 reset done", PINS'(setupDone), '0);
      #2;
      chk("R5 reset low slot", tracePins, '0);
    end
    rstN = 1'b1;
    for (int m = 0; m <= LAST_TICK; m++) tick(m);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule